// File: doc/BRIEF.md
# Peripheral ID to Channel Map Builder

After reset, this block walks a bank of per-channel arbiter map words and builds a lookup table. The table is indexed by a 12-bit peripheral ID and returns the hardware channel that serves that peripheral. Each channel has two inputs:

- a 32-bit map word, which carries the peripheral ID and an interrupt-ownership flag;
- an ownership word, which carries the write owner.

A local execution-environment number decides which channel wins when several channels claim the same peripheral ID.

Work starts at reset. The block first clears every table slot, one slot per cycle. It then visits each channel once, in ascending index order. Once the walk ends, `done` rises and lookups are served. A requester gives a slave ID and a 16-bit register address. One clock later it receives the channel index, a valid flag, and that channel's write owner and interrupt owner.

Top module: `pidmap_builder`

## Requirements
- R1: From reset until `done` is high, `busy` is high and `lk_valid` is low. After the walk, a peripheral ID that no channel claimed reads back with `lk_valid` low, `lk_chan` 0, `lk_wr_owner` 0 and `lk_irq_owner` 0xFF.
- R2: A map word equal to zero creates no table entry. Any non-zero map word creates or updates an entry, even when its peripheral ID field is zero.
- R3: The peripheral ID of a channel is bits 19:8 of its map word; all other bits of the word are ignored, except bit 14 (which also belongs to the ID field). The lookup ID is {lk_sid, lk_addr[15:8]}, and lk_addr[7:0] has no effect.
- R4: The first channel (lowest index) that claims a peripheral ID makes the entry valid and points it at that channel, whatever its owner. This holds for channel 0 and for channel NUM_CHAN-1.
- R5: A later channel whose write owner equals `local_ee` replaces the existing entry for its peripheral ID. Among several locally owned claimants, the highest index wins.
- R6: A later channel that is not locally owned and has bit 14 of its map word clear leaves the existing entry and both owners unchanged.
- R7: Consider a later channel that is not locally owned, has bit 14 set, and claims an ID whose current channel is locally owned. The entry keeps pointing at the current channel, but that channel's interrupt owner becomes the later channel's interrupt owner.
- R8: When the current channel of an entry is not locally owned, a later foreign channel with bit 14 set changes neither the entry nor any interrupt owner.
- R9: A channel's write owner is bits 2:0 of its ownership word; the upper bits are ignored. Its interrupt owner is 0xFF when map bit 14 is clear, and equals its write owner when map bit 14 is set. The only exception is a later transfer under R7.
- R10: Lookup outputs are registered. They reflect the `lk_sid`/`lk_addr` values present at the previous rising clock edge.
- R11: `done` rises exactly 4096 + NUM_CHAN rising edges after reset is released, and it stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; releasing it starts clear and walk |
| local_ee | input | 3 | Local execution-environment number |
| map_words | input | NUM_CHAN*32 | Map word of channel c at bits [32c+31:32c] |
| own_words | input | NUM_CHAN*32 | Ownership word of channel c at bits [32c+31:32c] |
| lk_sid | input | 4 | Lookup slave ID (upper four bits of the peripheral ID) |
| lk_addr | input | 16 | Lookup register address; the high byte forms the lower ID bits |
| lk_valid | output | 1 | Looked-up peripheral ID has a channel |
| lk_chan | output | $clog2(NUM_CHAN) | Channel index of the looked-up peripheral ID |
| lk_wr_owner | output | 3 | Write owner of that channel |
| lk_irq_owner | output | 8 | Interrupt owner of that channel, 0xFF for none |
| busy | output | 1 | Clear or walk in progress |
| done | output | 1 | Table complete, lookups served |

## Verification
The assertions assume that `map_words`, `own_words` and `local_ee` stay constant from reset release until `done`. The walk reads them live, so a change in the middle of a walk would break the ownership relations being checked. The bench sets every channel's words and the local number only while reset is held, and changes them only under a fresh reset.

The assertions also assume a reset at time zero. The bench holds `rst_n` low from the start. It moves `lk_sid` and `lk_addr` only on falling edges, so each registered lookup sees a single clean value.

// File: rtl/pidmap_pkg.sv
package pidmap_pkg;

    localparam int WORD_W      = 32;
    localparam int PID_W       = 12;
    localparam int PID_LSB     = 8;
    localparam int IRQ_BIT     = 14;
    localparam int OWNER_W     = 3;
    localparam int IRQOWN_W    = 8;
    localparam int ENTRY_IDX_W = 15;

    localparam logic [IRQOWN_W-1:0] IRQ_NONE = 8'hFF;

    typedef struct packed {
        logic                   valid;
        logic [ENTRY_IDX_W-1:0] idx;
    } pid_entry_t;

    typedef struct packed {
        logic [OWNER_W-1:0]  wr;
        logic [IRQOWN_W-1:0] irq;
    } chan_rec_t;

    typedef enum logic [1:0] {
        PH_CLEAR,
        PH_SCAN,
        PH_DONE
    } phase_e;

endpackage

// File: rtl/pidmap_decode.sv
module pidmap_decode
    import pidmap_pkg::*;
(
    input  logic [WORD_W-1:0]   map_word,
    input  logic [WORD_W-1:0]   own_word,
    output logic                present,
    output logic [PID_W-1:0]    pid,
    output logic                irq_own,
    output logic [OWNER_W-1:0]  wr_owner,
    output logic [IRQOWN_W-1:0] irq_owner
);

    logic unused_own_hi;

    always_comb begin
        present   = |map_word;
        pid       = map_word[PID_LSB +: PID_W];
        irq_own   = map_word[IRQ_BIT];
        wr_owner  = own_word[OWNER_W-1:0];
        irq_owner = irq_own ? IRQOWN_W'(wr_owner) : IRQ_NONE;
    end

    assign unused_own_hi = ^own_word[WORD_W-1:OWNER_W];

endmodule

// File: rtl/pidmap_table.sv
module pidmap_table
    import pidmap_pkg::*;
#(
    parameter int AW = PID_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  pid_entry_t    wdata,
    input  logic [AW-1:0] ra_addr,
    output pid_entry_t    ra_data,
    input  logic [AW-1:0] rb_addr,
    output pid_entry_t    rb_data
);

    localparam int DEPTH = 1 << AW;

    pid_entry_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign ra_data = mem_q[ra_addr];
    assign rb_data = mem_q[rb_addr];

endmodule

// File: rtl/pidmap_chan_store.sv
module pidmap_chan_store
    import pidmap_pkg::*;
#(
    parameter int NUM_CHAN = 64,
    parameter int CH_W     = $clog2(NUM_CHAN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rec_we,
    input  logic [CH_W-1:0]     rec_idx,
    input  logic [OWNER_W-1:0]  rec_wr,
    input  logic [IRQOWN_W-1:0] rec_irq,
    input  logic                xfer_we,
    input  logic [CH_W-1:0]     xfer_idx,
    input  logic [IRQOWN_W-1:0] xfer_irq,
    input  logic [CH_W-1:0]     rd_a_idx,
    output logic [OWNER_W-1:0]  rd_a_wr,
    input  logic [CH_W-1:0]     rd_b_idx,
    output logic [OWNER_W-1:0]  rd_b_wr,
    output logic [IRQOWN_W-1:0] rd_b_irq
);

    chan_rec_t slot_vec [NUM_CHAN];

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_slot
        chan_rec_t slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (rec_we && rec_idx == CH_W'(c)) begin
                slot_d.wr  = rec_wr;
                slot_d.irq = rec_irq;
            end
            if (xfer_we && xfer_idx == CH_W'(c)) begin
                slot_d.irq = xfer_irq;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q.wr  <= '0;
                slot_q.irq <= IRQ_NONE;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign slot_vec[c] = slot_q;
    end

    assign rd_a_wr  = slot_vec[rd_a_idx].wr;
    assign rd_b_wr  = slot_vec[rd_b_idx].wr;
    assign rd_b_irq = slot_vec[rd_b_idx].irq;

    // R9
    rec_irq_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_we |-> (rec_irq == IRQ_NONE || rec_irq == IRQOWN_W'(rec_wr)));

    // R7
    xfer_sep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_we && xfer_we) |-> (rec_idx != xfer_idx));

endmodule

// File: rtl/pidmap_builder.sv
module pidmap_builder
    import pidmap_pkg::*;
#(
    parameter int NUM_CHAN = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [OWNER_W-1:0]             local_ee,
    input  logic [NUM_CHAN*WORD_W-1:0]     map_words,
    input  logic [NUM_CHAN*WORD_W-1:0]     own_words,
    input  logic [PID_W-PID_LSB-1:0]       lk_sid,
    input  logic [15:0]                    lk_addr,
    output logic                           lk_valid,
    output logic [$clog2(NUM_CHAN)-1:0]    lk_chan,
    output logic [OWNER_W-1:0]             lk_wr_owner,
    output logic [IRQOWN_W-1:0]            lk_irq_owner,
    output logic                           busy,
    output logic                           done
);

    localparam int CH_W  = $clog2(NUM_CHAN);
    localparam int SID_W = PID_W - PID_LSB;

    typedef struct packed {
        phase_e              phase;
        logic [PID_W-1:0]    clr_idx;
        logic [CH_W-1:0]     ch_idx;
        logic                lk_valid;
        logic [CH_W-1:0]     lk_chan;
        logic [OWNER_W-1:0]  lk_wr;
        logic [IRQOWN_W-1:0] lk_irq;
    } ctrl_t;

    ctrl_t st_d, st_q;

    // current channel decode
    logic [WORD_W-1:0]   cur_map, cur_own;
    logic                dec_present, dec_irq;
    logic [PID_W-1:0]    dec_pid;
    logic [OWNER_W-1:0]  dec_wr;
    logic [IRQOWN_W-1:0] dec_irq_owner;

    assign cur_map = map_words[st_q.ch_idx*WORD_W +: WORD_W];
    assign cur_own = own_words[st_q.ch_idx*WORD_W +: WORD_W];

    pidmap_decode u_decode (
        .map_word  (cur_map),
        .own_word  (cur_own),
        .present   (dec_present),
        .pid       (dec_pid),
        .irq_own   (dec_irq),
        .wr_owner  (dec_wr),
        .irq_owner (dec_irq_owner)
    );

    // table
    logic             tbl_we;
    logic [PID_W-1:0] tbl_waddr;
    pid_entry_t       tbl_wdata, ra_data, rb_data;
    logic [PID_W-1:0] rb_addr;

    assign rb_addr = {lk_sid[SID_W-1:0], lk_addr[15:8]};

    pidmap_table #(.AW(PID_W)) u_table (
        .clk     (clk),
        .we      (tbl_we),
        .waddr   (tbl_waddr),
        .wdata   (tbl_wdata),
        .ra_addr (dec_pid),
        .ra_data (ra_data),
        .rb_addr (rb_addr),
        .rb_data (rb_data)
    );

    // channel records
    logic                rec_we, xfer_we;
    logic [CH_W-1:0]     xfer_idx, prev_ch, look_ch;
    logic [IRQOWN_W-1:0] xfer_irq, look_irq;
    logic [OWNER_W-1:0]  prev_wr, look_wr;

    assign prev_ch = ra_data.idx[CH_W-1:0];
    assign look_ch = rb_data.idx[CH_W-1:0];

    pidmap_chan_store #(.NUM_CHAN(NUM_CHAN), .CH_W(CH_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rec_we   (rec_we),
        .rec_idx  (st_q.ch_idx),
        .rec_wr   (dec_wr),
        .rec_irq  (dec_irq_owner),
        .xfer_we  (xfer_we),
        .xfer_idx (xfer_idx),
        .xfer_irq (xfer_irq),
        .rd_a_idx (prev_ch),
        .rd_a_wr  (prev_wr),
        .rd_b_idx (look_ch),
        .rd_b_wr  (look_wr),
        .rd_b_irq (look_irq)
    );

    always_comb begin
        st_d      = st_q;
        tbl_we    = 1'b0;
        tbl_waddr = st_q.clr_idx;
        tbl_wdata = '0;
        rec_we    = 1'b0;
        xfer_we   = 1'b0;
        xfer_idx  = prev_ch;
        xfer_irq  = dec_irq_owner;

        case (st_q.phase)
            PH_CLEAR: begin
                tbl_we       = 1'b1;
                st_d.clr_idx = st_q.clr_idx + 1'b1;
                if (st_q.clr_idx == '1) begin
                    st_d.phase = PH_SCAN;
                end
            end
            PH_SCAN: begin
                tbl_waddr = dec_pid;
                if (dec_present) begin
                    rec_we = 1'b1;
                    if (!ra_data.valid || dec_wr == local_ee) begin
                        tbl_we          = 1'b1;
                        tbl_wdata.valid = 1'b1;
                        tbl_wdata.idx   = ENTRY_IDX_W'(st_q.ch_idx);
                    end else if (dec_irq && prev_wr == local_ee) begin
                        xfer_we = 1'b1;
                    end
                end
                st_d.ch_idx = st_q.ch_idx + 1'b1;
                if (st_q.ch_idx == CH_W'(NUM_CHAN - 1)) begin
                    st_d.phase = PH_DONE;
                end
            end
            default: ;
        endcase

        if (st_q.phase == PH_DONE && rb_data.valid) begin
            st_d.lk_valid = 1'b1;
            st_d.lk_chan  = look_ch;
            st_d.lk_wr    = look_wr;
            st_d.lk_irq   = look_irq;
        end else begin
            st_d.lk_valid = 1'b0;
            st_d.lk_chan  = '0;
            st_d.lk_wr    = '0;
            st_d.lk_irq   = IRQ_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase    <= PH_CLEAR;
            st_q.clr_idx  <= '0;
            st_q.ch_idx   <= '0;
            st_q.lk_valid <= 1'b0;
            st_q.lk_chan  <= '0;
            st_q.lk_wr    <= '0;
            st_q.lk_irq   <= IRQ_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign lk_valid     = st_q.lk_valid;
    assign lk_chan      = st_q.lk_chan;
    assign lk_wr_owner  = st_q.lk_wr;
    assign lk_irq_owner = st_q.lk_irq;
    assign busy         = (st_q.phase != PH_DONE);
    assign done         = (st_q.phase == PH_DONE);

    logic unused_hi;
    assign unused_hi = ^{lk_addr[7:0], ra_data.idx[ENTRY_IDX_W-1:CH_W],
                         rb_data.idx[ENTRY_IDX_W-1:CH_W]};

    // R1
    lk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lk_valid |-> st_q.phase == PH_DONE);

    // R11
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase == PH_DONE |=> st_q.phase == PH_DONE);

    // R7
    xfer_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_we |-> (xfer_idx < st_q.ch_idx && prev_wr == local_ee));

    // R4
    scan_write_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we && st_q.phase == PH_SCAN) |-> tbl_wdata.valid);

endmodule

// File: tb/pidmap_builder_bench.sv
`timescale 1ns/1ps
module pidmap_builder_bench;

    localparam int NC    = 64;
    localparam int CW    = $clog2(NC);
    localparam int DEPTH = 4096;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        local_ee = '0;
    logic [NC*32-1:0]  map_words = '0;
    logic [NC*32-1:0]  own_words = '0;
    logic [3:0]        lk_sid = '0;
    logic [15:0]       lk_addr = '0;
    logic              lk_valid, busy, done;
    logic [CW-1:0]     lk_chan;
    logic [2:0]        lk_wr_owner;
    logic [7:0]        lk_irq_owner;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pidmap_builder #(.NUM_CHAN(NC)) u_pidmap_builder (
        .clk          (clk),
        .rst_n        (rst_n),
        .local_ee     (local_ee),
        .map_words    (map_words),
        .own_words    (own_words),
        .lk_sid       (lk_sid),
        .lk_addr      (lk_addr),
        .lk_valid     (lk_valid),
        .lk_chan      (lk_chan),
        .lk_wr_owner  (lk_wr_owner),
        .lk_irq_owner (lk_irq_owner),
        .busy         (busy),
        .done         (done)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic clear_cfg();
        map_words = '0;
        own_words = '0;
    endtask

    task automatic set_chan(int c, logic [31:0] w, logic [31:0] o);
        map_words[c*32 +: 32] = w;
        own_words[c*32 +: 32] = o;
    endtask

    // reset, check reset state (R1) and exact completion time (R11)
    task automatic build(logic [2:0] ee);
        rst_n = 1'b0;
        local_ee = ee;
        repeat (3) @(posedge clk);
        #1;
        check("R1 busy in reset", busy, 1);
        check("R1 done in reset", done, 0);
        check("R1 lk_valid in reset", lk_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (DEPTH + NC - 1) @(posedge clk);
        #1;
        check("R11 done one edge early", done, 0);
        @(posedge clk);
        #1;
        check("R11 done on time", done, 1);
        check("R11 busy low when done", busy, 0);
        @(negedge clk);
    endtask

    task automatic look(string tag, logic [3:0] sid, logic [15:0] addr,
                        logic v, logic [31:0] ch, logic [2:0] wr, logic [7:0] irq);
        @(negedge clk);
        lk_sid  = sid;
        lk_addr = addr;
        @(posedge clk);
        @(negedge clk);
        check({tag, " valid"}, lk_valid, v);
        check({tag, " chan"}, lk_chan, ch);
        check({tag, " wr_owner"}, lk_wr_owner, wr);
        check({tag, " irq_owner"}, lk_irq_owner, irq);
    endtask

    task automatic cfg_basic();
        clear_cfg();
        set_chan(0, 32'h0001_2300, 32'd2);
        set_chan(3, 32'h0000_8500, 32'd5);
        set_chan(5, 32'h0000_0001, 32'd1);
        set_chan(7, 32'hABC0_3300, 32'hFFFF_FFF9);
    endtask

    task automatic test_basic();
        cfg_basic();
        build(3'd2);
        look("R4 first claim ch0", 4'h1, 16'h2345, 1, 0, 2, 8'hFF);
        look("R3 low addr byte ignored", 4'h1, 16'h23FF, 1, 0, 2, 8'hFF);
        look("R4 foreign first claim", 4'h0, 16'h8511, 1, 3, 5, 8'hFF);
        look("R2 nonzero word pid 0", 4'h0, 16'h0042, 1, 5, 1, 8'hFF);
        look("R3 upper map bits ignored", 4'h0, 16'h3300, 1, 7, 1, 8'hFF);
        look("R1 unclaimed pid", 4'h2, 16'h0000, 0, 0, 0, 8'hFF);
    endtask

    task automatic test_zero();
        clear_cfg();
        build(3'd2);
        look("R2 zero words skipped", 4'h0, 16'h0000, 0, 0, 0, 8'hFF);
        look("R1 empty table", 4'hF, 16'hFF00, 0, 0, 0, 8'hFF);
    endtask

    task automatic test_busy_lookup();
        cfg_basic();
        rst_n = 1'b0;
        local_ee = 3'd2;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        lk_sid = 4'h1;
        lk_addr = 16'h2300;
        repeat (100) @(posedge clk);
        @(negedge clk);
        check("R1 lookup invalid while busy", lk_valid, 0);
        check("R1 busy while clearing", busy, 1);
        while (!done) @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R1 lookup valid after done", lk_valid, 1);
        check("R1 chan after done", lk_chan, 0);
    endtask

    task automatic test_latency();
        look("R10 setup", 4'h1, 16'h2300, 1, 0, 2, 8'hFF);
        @(negedge clk);
        lk_sid = 4'h2;
        lk_addr = 16'h0000;
        #1;
        check("R10 holds before edge", lk_valid, 1);
        @(posedge clk);
        #1;
        check("R10 updates after edge", lk_valid, 0);
    endtask

    task automatic cfg_prec();
        clear_cfg();
        set_chan(1, 32'h0000_C000, 32'd2);
        set_chan(2, 32'h0000_C000, 32'd5);
        set_chan(3, 32'h0000_1100, 32'd4);
        set_chan(6, 32'h0000_1100, 32'd2);
        set_chan(7, 32'h0000_1100, 32'd1);
        set_chan(8, 32'h0000_D000, 32'd3);
        set_chan(9, 32'h0000_D000, 32'd4);
        set_chan(10, 32'h0000_2200, 32'd2);
        set_chan(11, 32'h0000_2200, 32'd2);
        set_chan(12, 32'h0001_4000, 32'd2);
        set_chan(13, 32'h0001_4000, 32'd7);
        set_chan(14, 32'h0001_4000, 32'd2);
        set_chan(NC-1, 32'h0003_3F00, 32'd0);
    endtask

    task automatic test_prec_local2();
        cfg_prec();
        build(3'd2);
        look("R5 local replaces, R6 later foreign ignored", 4'h0, 16'h1100, 1, 6, 2, 8'hFF);
        look("R7 irq passed to local channel", 4'h0, 16'hC000, 1, 1, 2, 8'h05);
        look("R8 no pass to foreign channel", 4'h0, 16'hD000, 1, 8, 3, 8'h03);
        look("R5 highest local wins", 4'h0, 16'h2200, 1, 11, 2, 8'hFF);
        look("R9 replace after transfer", 4'h1, 16'h4000, 1, 14, 2, 8'h02);
        look("R4 last channel claim", 4'h3, 16'h3F80, 1, NC-1, 0, 8'hFF);
    endtask

    task automatic test_prec_local4();
        cfg_prec();
        build(3'd4);
        look("R6 foreign later keeps first", 4'h0, 16'h1100, 1, 3, 4, 8'hFF);
        look("R8 first not local no pass", 4'h0, 16'hC000, 1, 1, 2, 8'h02);
        look("R6 nonlocal pair keeps first", 4'h0, 16'h2200, 1, 10, 2, 8'hFF);
        look("R9 irq owner equals write owner", 4'h1, 16'h4000, 1, 12, 2, 8'h02);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        test_basic();
        test_latency();
        test_zero();
        test_busy_lookup();
        test_prec_local2();
        test_prec_local4();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule